// File: doc/BRIEF.md
# Periodic Drowsy Cache Line Controller

This block decides, line by line, whether a small cache data array sits on its full supply rail or on a low retention rail that cuts leakage. It does not watch which lines are busy. A single free-running period timer fires a global sleep pulse, and that pulse pushes every line into the drowsy state at once. A drowsy line keeps its contents, but its word line stays disabled. Because no per-line history or predictor is kept, the storage cost is one state bit per line plus one shared counter.

The cache pipeline presents a line index with a valid strobe and watches a ready signal. If the line is already awake, the access is granted at once and a one-hot word-line enable follows on the next cycle. If the line is drowsy, the same cycle moves it back to the high rail, and ready then drops for a programmable number of wake-up cycles. The requester keeps its request up, and the access is granted once ready returns. The sleep period is programmable. A typical value is a few thousand cycles, and a period of zero turns drowsy mode off.

Top module: `drowsy_line_ctrl`

## Requirements
- R1: With a nonzero period P, the global sleep pulse fires in the P-th cycle after reset and every P cycles after that. At the end of that cycle every line shows `rail_low` = 1 (1 = retention rail, 0 = full rail), except the lines R7 and R8 protect.
- R2: With a period of zero, no line ever changes from active to drowsy.
- R3: `wl_en` is zero or one-hot, and a bit of `wl_en` is never high while the same line shows `rail_low` = 1.
- R4: A request to an active line, made while `req_ready` is high, is accepted in that cycle. In the next cycle `wl_en` shows the one-hot bit of that line, and `req_ready` stays high.
- R5: A request to a drowsy line with a wake latency W > 0 makes the line active at the end of that cycle. `req_ready` is then low for exactly W cycles with `wl_en` zero. The held request is granted in the cycle `req_ready` returns high.
- R6: With W = 0, a request to a drowsy line is granted like R4, with no stall, and the line becomes active.
- R7: If the sleep pulse falls in the same cycle as an accepted or waking request, the requested line ends that cycle active and every other line ends it drowsy.
- R8: A line that is waking stays active through all of its stall cycles, even when sleep pulses fire during the stall.
- R9: After reset every line is active, `req_ready` is high and `wl_en` is zero.
- R10: While `req_ready` is low, new requests are ignored. They raise no `wl_en` bit and wake no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period_cfg | input | PERIOD_W | Sleep period in cycles; zero disables drowsy mode |
| wake_cfg | input | WAKE_W | Wake-up stall length in cycles |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | $clog2(NUM_LINES) | Index of the requested line |
| req_ready | output | 1 | High when a request can be accepted |
| wl_en | output | NUM_LINES | Registered one-hot word-line enable |
| rail_low | output | NUM_LINES | Per-line supply select, 1 = retention rail |

## Verification
The hardest situation to reach from the ports is a sleep pulse that lands exactly on the access cycle, or inside a wake stall. It needs the period, the wake length and the request timing to line up. The bench gets there in two ways. It runs short periods, down to a pulse every cycle, together with several wake lengths, using pseudo-random request streams checked against a cycle model. It also counts cycles from reset so that one directed request lands on the pulse cycle, and it holds a request through a stall while pulses fire on every cycle.

// File: rtl/drowsy_pkg.sv
package drowsy_pkg;
  typedef enum logic {
    ST_OPEN = 1'b0,
    ST_WAKE = 1'b1
  } acc_state_e;
endpackage

// File: rtl/drowsy_period_timer.sv
module drowsy_period_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt_q;

  // A zero period never fires. A shrinking period still fires via >=.
  assign tick = (period != '0) && (cnt_q >= period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (period == '0 || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/drowsy_state_bank.sv
module drowsy_state_bank #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 keep_vld,
  input  logic [IDX_W-1:0]     keep_idx,
  input  logic                 wake_vld,
  input  logic [IDX_W-1:0]     wake_idx,
  output logic [NUM_LINES-1:0] drowsy
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit_wake, hit_keep;
    assign hit_wake = wake_vld && (wake_idx == IDX_W'(g));
    assign hit_keep = keep_vld && (keep_idx == IDX_W'(g));

    // An access clears the bit and wins over a pulse in the same cycle.
    always_ff @(posedge clk) begin
      if (rst) begin
        drowsy[g] <= 1'b0;
      end else if (hit_wake) begin
        drowsy[g] <= 1'b0;
      end else if (tick && !hit_keep) begin
        drowsy[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/drowsy_access_ctrl.sv
module drowsy_access_ctrl
  import drowsy_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int WAKE_W    = 4,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [IDX_W-1:0]     req_addr,
  input  logic                 line_drowsy,
  input  logic [WAKE_W-1:0]    wake_cycles,
  output logic                 req_ready,
  output logic [NUM_LINES-1:0] wl_en,
  output logic                 clr_vld,
  output logic [IDX_W-1:0]     clr_idx,
  output logic                 keep_vld,
  output logic [IDX_W-1:0]     keep_idx
);
  acc_state_e          state_q;
  logic [WAKE_W-1:0]   wcnt_q;
  logic [IDX_W-1:0]    pend_q;
  logic                hit, need_wait, grant;
  logic [NUM_LINES-1:0] sel;

  assign req_ready = (state_q == ST_OPEN);
  assign hit       = req_valid && req_ready;
  assign need_wait = line_drowsy && (wake_cycles != '0);
  assign grant     = hit && !need_wait;

  assign clr_vld  = hit;
  assign clr_idx  = req_addr;
  assign keep_vld = (state_q == ST_WAKE);
  assign keep_idx = pend_q;

  always_comb begin
    sel = '0;
    sel[req_addr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wl_en <= '0;
    end else begin
      wl_en <= grant ? sel : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OPEN;
      wcnt_q  <= '0;
      pend_q  <= '0;
    end else begin
      case (state_q)
        ST_OPEN: begin
          if (hit && need_wait) begin
            state_q <= ST_WAKE;
            wcnt_q  <= wake_cycles - 1'b1;
            pend_q  <= req_addr;
          end
        end
        ST_WAKE: begin
          if (wcnt_q == '0) begin
            state_q <= ST_OPEN;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        default: state_q <= ST_OPEN;
      endcase
    end
  end
endmodule

// File: rtl/drowsy_line_ctrl.sv
module drowsy_line_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int PERIOD_W  = 16,
  parameter int WAKE_W    = 4,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PERIOD_W-1:0]  period_cfg,
  input  logic [WAKE_W-1:0]    wake_cfg,
  input  logic                 req_valid,
  input  logic [IDX_W-1:0]     req_addr,
  output logic                 req_ready,
  output logic [NUM_LINES-1:0] wl_en,
  output logic [NUM_LINES-1:0] rail_low
);
  logic                 tick;
  logic                 clr_vld, keep_vld;
  logic [IDX_W-1:0]     clr_idx, keep_idx;
  logic [NUM_LINES-1:0] drowsy;

  drowsy_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .period (period_cfg),
    .tick   (tick)
  );

  drowsy_access_ctrl #(.NUM_LINES(NUM_LINES), .WAKE_W(WAKE_W)) u_access (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .line_drowsy (drowsy[req_addr]),
    .wake_cycles (wake_cfg),
    .req_ready   (req_ready),
    .wl_en       (wl_en),
    .clr_vld     (clr_vld),
    .clr_idx     (clr_idx),
    .keep_vld    (keep_vld),
    .keep_idx    (keep_idx)
  );

  drowsy_state_bank #(.NUM_LINES(NUM_LINES)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .keep_vld (keep_vld),
    .keep_idx (keep_idx),
    .wake_vld (clr_vld),
    .wake_idx (clr_idx),
    .drowsy   (drowsy)
  );

  assign rail_low = drowsy;
endmodule

// File: rtl/drowsy_line_ctrl_checker.sv
module drowsy_line_ctrl_checker #(
  parameter int NUM_LINES = 8,
  parameter int PERIOD_W  = 16,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [PERIOD_W-1:0]  period_cfg,
  input logic                 req_valid,
  input logic [IDX_W-1:0]     req_addr,
  input logic                 req_ready,
  input logic [NUM_LINES-1:0] wl_en,
  input logic [NUM_LINES-1:0] rail_low
);
  assert_wl_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wl_en));

  assert_wl_awake_R3: assert property (@(posedge clk) disable iff (rst)
    (wl_en & rail_low) == '0);

  assert_active_grant_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !rail_low[req_addr]) |=> wl_en[$past(req_addr)]);

  assert_stall_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> wl_en == '0);

  assert_access_awake_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !rail_low[$past(req_addr)]);

  assert_no_sleep_R2: assert property (@(posedge clk) disable iff (rst)
    (period_cfg == '0 && $past(period_cfg) == '0) |-> (rail_low & ~$past(rail_low)) == '0);
endmodule

bind drowsy_line_ctrl drowsy_line_ctrl_checker #(
  .NUM_LINES(NUM_LINES),
  .PERIOD_W (PERIOD_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .period_cfg (period_cfg),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_ready  (req_ready),
  .wl_en      (wl_en),
  .rail_low   (rail_low)
);

// File: tb/drowsy_line_ctrl_bench.sv
module drowsy_line_ctrl_bench;
  localparam int LINES = 4;
  localparam int PW    = 8;
  localparam int WW    = 3;
  localparam int AW    = $clog2(LINES);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PW-1:0]   period_cfg = '0;
  logic [WW-1:0]   wake_cfg = '0;
  logic            req_valid = 1'b0;
  logic [AW-1:0]   req_addr = '0;
  logic            req_ready;
  logic [LINES-1:0] wl_en, rail_low;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  drowsy_line_ctrl #(.NUM_LINES(LINES), .PERIOD_W(PW), .WAKE_W(WW)) u_drowsy_line_ctrl (
    .clk(clk), .rst(rst), .period_cfg(period_cfg), .wake_cfg(wake_cfg),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .wl_en(wl_en), .rail_low(rail_low)
  );

  // Cycle model written from the requirements
  logic [PW-1:0]    m_cnt;
  logic [LINES-1:0] m_sleep, m_wl;
  logic             m_ready;
  logic [WW-1:0]    m_wait;
  logic [AW-1:0]    m_pend;

  always @(posedge clk) begin
    logic             pulse, take, slow;
    logic [LINES-1:0] nxt;
    if (rst) begin
      m_cnt <= '0; m_sleep <= '0; m_wl <= '0; m_ready <= 1'b1;
      m_wait <= '0; m_pend <= '0;
    end else begin
      pulse = (period_cfg != 0) && (m_cnt >= period_cfg - 1);
      m_cnt <= (period_cfg == 0 || pulse) ? '0 : m_cnt + 1'b1;
      take = req_valid && m_ready;
      slow = take && m_sleep[req_addr] && (wake_cfg != 0);
      nxt = m_sleep;
      if (pulse) begin
        nxt = '1;
        if (!m_ready) nxt[m_pend] = 1'b0;
      end
      if (take) nxt[req_addr] = 1'b0;
      m_sleep <= nxt;
      m_wl <= (take && !slow) ? (LINES'(1) << req_addr) : '0;
      if (slow) begin
        m_ready <= 1'b0; m_wait <= wake_cfg - 1'b1; m_pend <= req_addr;
      end else if (!m_ready) begin
        if (m_wait == 0) m_ready <= 1'b1;
        else m_wait <= m_wait - 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  bit    cmp_on = 0;
  string rail_tag = "R1 R7 R8 line state";

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(rail_tag, 32'(rail_low), 32'(m_sleep));
      chk("R5 R6 R10 ready", 32'(req_ready), 32'(m_ready));
      chk("R3 R4 R10 wl_en", 32'(wl_en), 32'(m_wl));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    req_valid = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    int stall;
    // R9 reset state
    do_reset();
    chk("R9 rail_low", 32'(rail_low), 0);
    chk("R9 ready", 32'(req_ready), 1);
    chk("R9 wl_en", 32'(wl_en), 0);

    // R7: pulse in the 5th cycle after reset, access line 0 in that cycle
    period_cfg = 5; wake_cfg = 2;
    do_reset();
    repeat (4) @(negedge clk);
    req_valid = 1; req_addr = 0;
    @(negedge clk); req_valid = 0;
    chk("R7 rail_low", 32'(rail_low), 32'b1110);
    chk("R7 wl_en", 32'(wl_en), 32'b0001);

    // R5: stall count on a drowsy line, W = 3
    period_cfg = 6; wake_cfg = 3;
    do_reset();
    repeat (8) @(negedge clk);
    chk("R1 all drowsy", 32'(rail_low), 32'b1111);
    req_valid = 1; req_addr = 2;
    @(negedge clk);
    chk("R5 line awake", 32'(rail_low[2]), 0);
    stall = 0;
    while (req_ready == 0 && stall < 20) begin
      chk("R5 no wl in stall", 32'(wl_en), 0);
      stall++;
      @(negedge clk);
    end
    chk("R5 stall length", 32'(stall), 3);
    @(negedge clk);
    req_valid = 0;
    chk("R5 grant after stall", 32'(wl_en), 32'b0100);

    // R6: zero wake latency
    period_cfg = 4; wake_cfg = 0;
    do_reset();
    repeat (6) @(negedge clk);
    req_valid = 1; req_addr = 1;
    @(negedge clk); req_valid = 0;
    chk("R6 ready", 32'(req_ready), 1);
    chk("R6 wl_en", 32'(wl_en), 32'b0010);

    // R8: pulse every cycle during a 4-cycle stall
    period_cfg = 1; wake_cfg = 4;
    do_reset();
    repeat (2) @(negedge clk);
    req_valid = 1; req_addr = 3;
    @(negedge clk);
    while (req_ready == 0) begin
      chk("R8 waking line kept", 32'(rail_low), 32'b0111);
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
    chk("R8 grant", 32'(wl_en), 32'b1000);

    // R2: period zero, random traffic
    period_cfg = 0; wake_cfg = 3;
    do_reset();
    cmp_on = 1; rail_tag = "R2 no sleep";
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      req_valid = lfsr[0] | lfsr[1]; req_addr = lfsr[3:2];
      @(negedge clk);
    end
    chk("R2 all active", 32'(rail_low), 0);
    rail_tag = "R1 R7 R8 line state";

    // Sweep of periods and wake lengths against the model
    for (int w = 0; w < 5; w++) begin
      for (int p = 1; p < 10; p += 2) begin
        cmp_on = 0;
        period_cfg = PW'(p); wake_cfg = WW'(w);
        do_reset();
        cmp_on = 1;
        for (int i = 0; i < 300; i++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          req_valid = lfsr[0] | lfsr[4]; req_addr = lfsr[6:5];
          @(negedge clk);
        end
      end
    end
    cmp_on = 0;
    req_valid = 0;
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule